// File: doc/BRIEF.md
# Page-Mode Pseudo-SRAM Read Controller

This block turns word-read requests from a synchronous system into the asynchronous pin sequence of a 16-bit pseudo-SRAM that supports fast in-page reads. A request carries a start word address and a burst length. The controller opens the memory with a full random-access cycle. For every following word that stays in the same 8-word page, it moves only the three low address bits and uses the shorter in-page cycle. It returns each captured word together with its address. A done flag marks the final word.

Every analogue timing limit is a nanosecond parameter. It is turned into a clock-cycle count against a clock-period parameter: minimums round up and the chip-enable maximum rounds down. When a burst crosses a page boundary, chip enable goes high for its minimum high time and a new random cycle opens the next page. Chip enable also goes high in the same way when one more in-page cycle would hold it low past the maximum window.

Top module: `psram_page_rd`

## Requirements
- R1: During and straight after reset, chip enable, output enable and the address-latch strobe are high (inactive), `req_ready` is 1 and `rd_valid` is 0.
- R2: `req_ready` is 1 only while the controller is idle. A request is accepted on a clock edge with `req_valid` and `req_ready` both 1. `req_len` holds the word count minus one. The burst returns exactly `req_len`+1 words with addresses start, start+1, … (modulo the address width), each with the data present on `mem_dq` when it was sampled. Requests offered while busy have no effect.
- R3: `rd_last` is 1 together with `rd_valid` on the final word of a burst and 0 on every other word.
- R4: A random cycle pulls chip enable and the address strobe low on the same edge. The strobe stays low for ceil(tVPL) cycles. Output enable falls max(ceil(tVPL), ceil(tASO)) cycles after chip enable. The word is sampled max(ceil(tRC), ceil(tBA), that output-enable delay + ceil(tOE), ceil(tVPL)+ceil(tAHV)) cycles after chip enable falls.
- R5: While chip enable stays low, only address bits [2:0] change. Each in-page word is sampled max(ceil(tPRC), ceil(tPAA)) cycles after the previous one.
- R6: After sampling a word whose address bits [2:0] are 3'b111, a continuing burst raises chip enable for ceil(tCP) cycles and then starts a random cycle.
- R7: Chip enable is never low for more than floor(tCEmax/clock) cycles. If one more in-page cycle would go past that, the controller raises chip enable as in R6 instead.
- R8: Chip enable stays high for at least ceil(tCP) cycles between low periods. `req_ready` returns exactly ceil(tCP) cycles after the final word of a burst is sampled.
- R9: Both byte-lane enables are low exactly while chip enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Number of words minus one |
| mem_addr | output | AW | Word address to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_adv_n | output | 1 | Address-latch strobe, active low |
| mem_lb_n | output | 1 | Lower byte lane enable, active low |
| mem_ub_n | output | 1 | Upper byte lane enable, active low |
| mem_dq | input | 16 | Read data from the memory |
| rd_valid | output | 1 | One-cycle strobe for a returned word |
| rd_data | output | 16 | Returned word |
| rd_addr | output | AW | Address of the returned word |
| rd_last | output | 1 | Returned word is the last of its burst |

## Verification
A phase counter that runs one cycle short or long moves the sampling edge against the memory's access windows. This shows up on the first affected word as a corrupted `rd_data` and as an arrival cycle that differs from the arithmetic schedule. A wrong page-end or window decision shows at the pins within one word. Chip enable either stays low across a change of the upper address bits, or it rises where the schedule predicts another in-page word. A wrong remaining-word count shows up at the end of the burst as a missing, extra or mislabelled final word, and `req_ready` comes back at the wrong cycle.

// File: rtl/psram_rd_pkg.sv
`timescale 1ns/1ps
package psram_rd_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RAND, ST_PAGE, ST_GAP} rd_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // minimum limits: round up to whole cycles
  function automatic int ns_up(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  // maximum limits: round down to whole cycles
  function automatic int ns_dn(input int ns, input int clk_ns);
    return ns / clk_ns;
  endfunction

  function automatic int oe_start(input int clk_ns, input int vpl_ns, input int aso_ns);
    return imax(imax(ns_up(vpl_ns, clk_ns), ns_up(aso_ns, clk_ns)), 1);
  endfunction

  function automatic int rand_cycles(input int clk_ns, input int rc_ns, input int ba_ns,
                                     input int oe_ns, input int vpl_ns, input int aso_ns,
                                     input int ahv_ns);
    int by_oe;
    int by_adv;
    by_oe  = oe_start(clk_ns, vpl_ns, aso_ns) + ns_up(oe_ns, clk_ns);
    by_adv = ns_up(vpl_ns, clk_ns) + ns_up(ahv_ns, clk_ns);
    return imax(imax(ns_up(rc_ns, clk_ns), ns_up(ba_ns, clk_ns)), imax(by_oe, by_adv));
  endfunction

endpackage

// File: rtl/psram_rd_burst.sv
`timescale 1ns/1ps
module psram_rd_burst #(
  parameter int AW = 23,
  parameter int LW = 4,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic          last_word,
  output logic          page_end
);
  logic [LW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= ld_addr;
      remain   <= ld_len;
    end else if (step) begin
      cur_addr <= cur_addr + 1'b1;
      remain   <= remain - 1'b1;
    end
  end

  assign last_word = (remain == '0);
  assign page_end  = &cur_addr[PW-1:0];
endmodule

// File: rtl/psram_rd_cetimer.sv
`timescale 1ns/1ps
module psram_rd_cetimer #(
  parameter int CEMAX_CYC = 200,
  parameter int PAGE_CYC  = 4,
  parameter int CP_CYC    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  output logic page_fits
);
  localparam int LOW_W = $clog2(CEMAX_CYC + PAGE_CYC + 2);
  localparam int HI_W  = $clog2(CP_CYC + 1) + 1;

  logic [LOW_W-1:0] lo_age;   // edges seen with chip enable low
  logic [HI_W-1:0]  hi_run;   // edges seen with chip enable high, saturating

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_age <= '0;
      hi_run <= HI_W'(CP_CYC);
    end else begin
      lo_age <= ce_n ? '0 : ((lo_age == '1) ? lo_age : lo_age + 1'b1);
      if (!ce_n)                        hi_run <= '0;
      else if (hi_run != HI_W'(CP_CYC)) hi_run <= hi_run + 1'b1;
    end
  end

  // one more in-page cycle keeps the low time inside the window
  assign page_fits = (32'(lo_age) + 32'(PAGE_CYC) + 32'd1) <= 32'(CEMAX_CYC);

  a_r7_ce_window: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> (32'(lo_age) < 32'(CEMAX_CYC)));

  a_r8_ce_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_n) |-> (32'(hi_run) >= 32'(CP_CYC)));
endmodule

// File: rtl/psram_rd_seq.sv
`timescale 1ns/1ps
module psram_rd_seq import psram_rd_pkg::*; #(
  parameter int RAND_CYC = 14,
  parameter int PAGE_CYC = 4,
  parameter int CP_CYC   = 3,
  parameter int VPL_CYC  = 2,
  parameter int OE_AT    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic last_word,
  input  logic page_end,
  input  logic page_fits,
  output logic req_ready,
  output logic load,
  output logic capture,
  output logic ce_n,
  output logic oe_n,
  output logic adv_n
);
  localparam int LONGEST = imax(imax(RAND_CYC, PAGE_CYC), CP_CYC);
  localparam int SW      = $clog2(LONGEST + 1);

  rd_state_t st, st_d;
  logic [SW-1:0] cnt, cnt_d;
  logic pend, pend_d;
  logic word_done;

  // pin levels that belong to a given state and phase, as {ce_n, oe_n, adv_n}
  function automatic logic [2:0] pins_for(input rd_state_t s, input logic [SW-1:0] c);
    logic ce_on, oe_on, adv_on;
    ce_on  = (s == ST_RAND) || (s == ST_PAGE);
    adv_on = (s == ST_RAND) && (c < SW'(VPL_CYC));
    oe_on  = (s == ST_PAGE) || ((s == ST_RAND) && (c >= SW'(OE_AT)));
    return {~ce_on, ~oe_on, ~adv_on};
  endfunction

  assign word_done = ((st == ST_RAND) && (cnt == SW'(RAND_CYC - 1))) ||
                     ((st == ST_PAGE) && (cnt == SW'(PAGE_CYC - 1)));

  always_comb begin
    st_d   = st;
    cnt_d  = cnt + 1'b1;
    pend_d = pend;
    load   = 1'b0;
    case (st)
      ST_IDLE: begin
        cnt_d = '0;
        if (req_valid) begin
          load = 1'b1;
          st_d = ST_RAND;
        end
      end
      ST_RAND, ST_PAGE: begin
        if (word_done) begin
          cnt_d = '0;
          if (last_word) begin
            st_d   = ST_GAP;
            pend_d = 1'b0;
          end else if (!page_end && page_fits) begin
            st_d = ST_PAGE;
          end else begin
            st_d   = ST_GAP;
            pend_d = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (cnt == SW'(CP_CYC - 1)) begin
          cnt_d = '0;
          st_d  = pend ? ST_RAND : ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st                 <= ST_IDLE;
      cnt                <= '0;
      pend               <= 1'b0;
      {ce_n, oe_n, adv_n} <= 3'b111;
    end else begin
      st                 <= st_d;
      cnt                <= cnt_d;
      pend               <= pend_d;
      {ce_n, oe_n, adv_n} <= pins_for(st_d, cnt_d);
    end
  end

  assign capture   = word_done;
  assign req_ready = (st == ST_IDLE);

  a_r4_adv_opens_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adv_n) |-> $fell(ce_n));

  a_r4_oe_clear_of_adv: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> adv_n);

  a_r2_ready_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && oe_n));
endmodule

// File: rtl/psram_page_rd.sv
`timescale 1ns/1ps
module psram_page_rd import psram_rd_pkg::*; #(
  parameter int AW          = 23,
  parameter int LW          = 4,
  parameter int PW          = 3,
  parameter int CLK_NS      = 5,
  parameter int T_RC_NS     = 70,
  parameter int T_BA_NS     = 30,
  parameter int T_OE_NS     = 40,
  parameter int T_PRC_NS    = 20,
  parameter int T_PAA_NS    = 20,
  parameter int T_VPL_NS    = 10,
  parameter int T_AHV_NS    = 5,
  parameter int T_ASO_NS    = 10,
  parameter int T_CP_NS     = 15,
  parameter int T_CE_MAX_NS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_adv_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  input  logic [15:0]   mem_dq,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          rd_last
);
  localparam int RAND_CYC  = rand_cycles(CLK_NS, T_RC_NS, T_BA_NS, T_OE_NS,
                                         T_VPL_NS, T_ASO_NS, T_AHV_NS);
  localparam int PAGE_CYC  = imax(imax(ns_up(T_PRC_NS, CLK_NS), ns_up(T_PAA_NS, CLK_NS)), 1);
  localparam int CP_CYC    = imax(ns_up(T_CP_NS, CLK_NS), 1);
  localparam int VPL_CYC   = imax(ns_up(T_VPL_NS, CLK_NS), 1);
  localparam int OE_AT     = oe_start(CLK_NS, T_VPL_NS, T_ASO_NS);
  localparam int CEMAX_CYC = ns_dn(T_CE_MAX_NS, CLK_NS);

  logic load, capture, last_word, page_end, page_fits;
  logic [AW-1:0] cur_addr;

  psram_rd_burst #(.AW(AW), .LW(LW), .PW(PW)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(req_addr), .ld_len(req_len),
    .step(capture), .cur_addr(cur_addr), .last_word(last_word), .page_end(page_end)
  );

  psram_rd_cetimer #(.CEMAX_CYC(CEMAX_CYC), .PAGE_CYC(PAGE_CYC), .CP_CYC(CP_CYC)) u_cetimer (
    .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .page_fits(page_fits)
  );

  psram_rd_seq #(
    .RAND_CYC(RAND_CYC), .PAGE_CYC(PAGE_CYC), .CP_CYC(CP_CYC),
    .VPL_CYC(VPL_CYC), .OE_AT(OE_AT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .last_word(last_word),
    .page_end(page_end), .page_fits(page_fits), .req_ready(req_ready), .load(load),
    .capture(capture), .ce_n(mem_ce_n), .oe_n(mem_oe_n), .adv_n(mem_adv_n)
  );

  assign mem_addr = cur_addr;
  assign mem_lb_n = mem_ce_n;
  assign mem_ub_n = mem_ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_addr  <= '0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= capture;
      rd_last  <= capture && last_word;
      if (capture) begin
        rd_data <= mem_dq;
        rd_addr <= cur_addr;
      end
    end
  end

  a_r5_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> (mem_addr[AW-1:PW] == $past(mem_addr[AW-1:PW])));

  a_r3_last_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);
endmodule

// File: tb/tb_psram_page_rd.sv
`timescale 1ns/1ps
module tb_psram_page_rd;
  localparam int AW = 8;
  localparam int LW = 4;
  localparam int CK = 5;
  localparam int CEMAX_NS = 130;

  // cycle counts restated from the timing figures
  localparam int RC_C   = (70 + CK - 1) / CK;
  localparam int BA_C   = (30 + CK - 1) / CK;
  localparam int OE_C   = (40 + CK - 1) / CK;
  localparam int PRC_C  = (20 + CK - 1) / CK;
  localparam int VPL_C  = (10 + CK - 1) / CK;
  localparam int AHV_C  = (5 + CK - 1) / CK;
  localparam int ASO_C  = (10 + CK - 1) / CK;
  localparam int CP_C   = (15 + CK - 1) / CK;
  localparam int CEMX_C = CEMAX_NS / CK;
  localparam int OEAT_C = (VPL_C > ASO_C) ? VPL_C : ASO_C;
  localparam int R_A    = (RC_C > BA_C) ? RC_C : BA_C;
  localparam int R_B    = ((OEAT_C + OE_C) > (VPL_C + AHV_C)) ? (OEAT_C + OE_C) : (VPL_C + AHV_C);
  localparam int RND_C  = (R_A > R_B) ? R_A : R_B;
  localparam int PG_C   = PRC_C;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_adv_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq;
  logic rd_valid, rd_last;
  logic [15:0] rd_data;
  logic [AW-1:0] rd_addr;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psram_page_rd #(.AW(AW), .LW(LW), .T_CE_MAX_NS(CEMAX_NS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_adv_n(mem_adv_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq(mem_dq), .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr),
    .rd_last(rd_last)
  );

  function automatic logic [15:0] mdata(input logic [AW-1:0] a);
    return {~a, a} ^ 16'h3C69;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---- behavioural memory: ages counted in cycles, data only when every window is met
  int ce_age = 1000, oe_age = 1000, up_age = 1000, lo_age = 1000, hi_age = 1000, adv_age = 1000;
  logic p_ce = 1'b1, p_oe = 1'b1, p_adv = 1'b1;
  logic [AW-1:0] p_addr = '0;
  logic dq_ok;

  assign dq_ok = !mem_ce_n && !mem_oe_n && ce_age >= RC_C && ce_age >= BA_C &&
                 oe_age >= OE_C && up_age >= RC_C && lo_age >= PRC_C;
  assign mem_dq = dq_ok ? mdata(mem_addr) : 16'hBAD0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && p_ce) chk(hi_age >= CP_C, "R8 ce high time", hi_age, CP_C);
      if (mem_ce_n && !p_ce) chk(ce_age <= CEMX_C, "R7 ce low time", ce_age, CEMX_C);
      if (mem_adv_n && !p_adv) chk(adv_age == VPL_C, "R4 strobe width", adv_age, VPL_C);
      if (!mem_oe_n && p_oe) chk(lo_age >= ASO_C && up_age >= ASO_C, "R4 addr setup to oe",
                                 lo_age, ASO_C);
      if (!mem_ce_n && !p_ce)
        chk(mem_addr[AW-1:3] == p_addr[AW-1:3], "R5 upper bits held",
            int'(mem_addr), int'(p_addr));
      chk(mem_lb_n == mem_ce_n && mem_ub_n == mem_ce_n, "R9 byte lanes",
          int'({mem_lb_n, mem_ub_n}), int'({mem_ce_n, mem_ce_n}));
    end
    ce_age  <= mem_ce_n ? 0 : ((ce_age < 1000) ? ce_age + 1 : ce_age);
    oe_age  <= mem_oe_n ? 0 : ((oe_age < 1000) ? oe_age + 1 : oe_age);
    adv_age <= mem_adv_n ? 0 : adv_age + 1;
    hi_age  <= !mem_ce_n ? 0 : ((hi_age < 1000) ? hi_age + 1 : hi_age);
    up_age  <= (mem_addr[AW-1:3] != p_addr[AW-1:3]) ? 1 : ((up_age < 1000) ? up_age + 1 : up_age);
    lo_age  <= (mem_addr[2:0] != p_addr[2:0]) ? 1 : ((lo_age < 1000) ? lo_age + 1 : lo_age);
    p_ce   <= mem_ce_n;
    p_oe   <= mem_oe_n;
    p_adv  <= mem_adv_n;
    p_addr <= mem_addr;
  end

  // ---- one burst: expected arrival offsets computed from the schedule rules
  task automatic run_burst(input int s, input int l);
    int off[16];
    string why[16];
    int used, t, acc, got, guard, last_cyc, w;
    int n;
    n = l + 1;
    used = 0;
    t = 0;
    for (int i = 0; i < n; i++) begin
      int a;
      a = (s + i) % 256;
      if (i == 0) begin
        t = RND_C; used = RND_C; why[i] = "R4 first word";
      end else if ((a % 8) != 0 && used + PG_C <= CEMX_C) begin
        t += PG_C; used += PG_C; why[i] = "R5 in-page word";
      end else begin
        t += CP_C + RND_C; used = RND_C;
        why[i] = ((a % 8) == 0) ? "R6 page reopen" : "R7 window reopen";
      end
      off[i] = t;
    end

    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    req_addr  = AW'(s);
    req_len   = LW'(l);
    req_valid = 1'b1;
    acc = cyc + 1;
    @(negedge clk);
    req_addr = AW'(s) ^ 8'h80;    // busy-time request must be ignored (R2)
    req_len  = 4'hF;

    got = 0;
    guard = 0;
    while (got < n && guard < 600) begin
      chk(!req_ready, "R2 ready low while busy", int'(req_ready), 0);
      if (rd_valid) begin
        chk(rd_addr == AW'(s + got), "R2 word address", int'(rd_addr), (s + got) % 256);
        chk(rd_data == mdata(AW'(s + got)), "R2 word data", int'(rd_data),
            int'(mdata(AW'(s + got))));
        chk(cyc - acc == off[got], why[got], cyc - acc, off[got]);
        chk(rd_last == (got == n - 1), "R3 last flag", int'(rd_last), int'(got == n - 1));
        got++;
      end
      if (got < n) @(negedge clk);
      guard++;
    end
    chk(got == n, "R2 word count", got, n);
    last_cyc = cyc;
    req_valid = 1'b0;
    w = 0;
    while (!req_ready && w < 50) begin
      @(negedge clk);
      if (rd_valid) chk(0, "R2 extra word", 1, 0);
      w++;
    end
    chk(cyc - last_cyc == CP_C, "R8 ready return", cyc - last_cyc, CP_C);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_len = '0;
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_adv_n, "R1 pins in reset",
        int'({mem_ce_n, mem_oe_n, mem_adv_n}), 7);
    chk(!rd_valid && req_ready, "R1 handshake in reset", int'({rd_valid, req_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_adv_n && req_ready && !rd_valid, "R1 after reset",
        int'({mem_ce_n, mem_oe_n, mem_adv_n, req_ready, rd_valid}), 30);
    for (int s = 0; s < 16; s++)
      for (int l = 0; l < 16; l++)
        run_burst(s, l);
    run_burst(250, 15);
    run_burst(3, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule